// File: doc/BRIEF.md
# GPU Rail Power-Cycle Sequencer

This block brings a five-rail accelerator supply up and down in a fixed order. A power-on request first holds the accelerator in reset. It then switches on the 1.8 V, 3.3 V, core, PCIe and frame-buffer rails one at a time, and each rail waits for its power-good before the next is switched. With every rail good it raises a combined rails-good output, waits one millisecond, and releases reset.

A power-off request runs the reverse order. It asserts reset, waits five milliseconds and drops rails-good. It then switches the rails off from frame-buffer down to 1.8 V. After each rail's power-good falls, the block holds a fixed discharge dwell before it moves to the next rail.

All time is counted in ticks of a one-millisecond strobe. Every power-good wait is bounded. A wait that runs out raises a sticky error flag and the sequence goes on. The power-good inputs are asynchronous and pass through two flip-flops before the state machine uses them.

Top module: `gpu_rail_seq`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the outputs are: `rail_en` = 5'b10000 (every rail off), `rails_good` = 0, `gpu_rst_n` = 0, `busy` = 0, `done` = 0 and `timeout_err` = 0.
- R2: Power-up enables the rails in bit order 0 (1.8 V), 1 (3.3 V), 2 (core), 3 (PCIe), 4 (frame-buffer). A rail is enabled only after the power-good of the previous rail is high, unless that previous wait timed out.
- R3: `rail_en[4]` (frame-buffer) is active-low and bits 0 to 3 are active-high. All rails on reads 5'b01111 and all rails off reads 5'b10000.
- R4: During power-up the power-good waits of rails 0 and 1 are bounded at `T_UP_SLOW` ticks (20) and those of rails 2 to 4 at `T_UP_FAST` ticks (5). When a bound runs out, `timeout_err` is set and the next rail is enabled.
- R5: When all rails are done, `rails_good` rises. Exactly `T_HOLD` ticks (1) later `gpu_rst_n` rises, and the sequence then finishes.
- R6: Power-down drives `gpu_rst_n` low first. `rails_good` falls exactly `T_RST_LEAD` ticks (5) after that.
- R7: Power-down disables the rails in order 4, 3, 2, 1, 0. Each waits up to `T_DN_WAIT` ticks (20) for its power-good to fall. A wait that runs out sets `timeout_err` and the sequence continues.
- R8: After power-good falls, the next rail is disabled only after a dwell of 40 ticks (after rail 4), 10 (after rail 3), 2 (after rail 2) or 4 (after rail 1). There is no dwell after rail 0.
- R9: `timeout_err` stays set until the next accepted request clears it.
- R10: A request that arrives while `busy` is high has no effect and is not queued.
- R11: A power-good change reaches the sequence only through a two-stage synchronizer. The next rail's enable therefore changes no earlier than four clocks after the raw power-good edge.
- R12: `busy` rises on the clock that accepts a request and stays high through the cycle in which `done` pulses high for exactly one clock.
- R13: If both requests arrive together while idle, the power-on request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock strobe, once per millisecond |
| pwr_on_req | input | 1 | Power-up request pulse |
| pwr_off_req | input | 1 | Power-down request pulse |
| pg_in | input | 5 | Raw power-good per rail, bit 0 = 1.8 V ... bit 4 = frame-buffer |
| rail_en | output | 5 | Rail enable pins at pin level, bit 4 active-low |
| rails_good | output | 1 | Combined rails-good indication |
| gpu_rst_n | output | 1 | Accelerator reset, active-low |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-clock pulse at the end of a sequence |
| timeout_err | output | 1 | Sticky flag: a power-good wait ran out |

## Verification
The bench drives a rail model that follows each enable after a short delay and can freeze any power-good. It uses the model to test three kinds of fault.

First, order and timing. A design that skips a power-good wait or swaps two rails shows up when an enable comes before the previous power-good. A wrong dwell or lead time shows up in the counted ticks between edges.

Second, a frozen power-good. It must give a timeout of the right length, the sequence must continue, and the flag must stay set and then clear on the next request. A design that hangs, clears the flag early or uses the wrong bound is caught here.

Third, stray requests and resets. Requests arriving mid-sequence and a reset mid-sequence must leave no trace, and a design that aborts or queues them is caught.

// File: rtl/gpu_seq_pkg.sv
package gpu_seq_pkg;
  localparam int unsigned NR = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_UP_ON, S_UP_PG, S_UP_HOLD,
    S_DN_RST, S_DN_OFF, S_DN_PG, S_DN_DWELL, S_DONE
  } seq_st_t;

  typedef logic [2:0] rail_idx_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // logical "on" vector to pin levels; set mask bits mark active-low pins
  function automatic logic [NR-1:0] to_pins(input logic [NR-1:0] on_v,
                                            input logic [NR-1:0] low_mask);
    return on_v ^ low_mask;
  endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sync
);
  logic [W-1:0] stage1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[b] <= 1'b0;
        sync[b]   <= 1'b0;
      end else begin
        stage1[b] <= raw[b];
        sync[b]   <= stage1[b];
      end
    end
  end

  // warm-up count so the lag check never looks before reset
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_sync_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (sync == $past(raw, 2)));
endmodule

// File: rtl/ms_timer.sv
module ms_timer #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (restart)               count <= '0;
    else if (tick && count != CMAX) count <= count + 1'b1;
  end

  assert_tmr_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && !restart) |=> (count == CMAX));
endmodule

// File: rtl/gpu_rail_seq.sv
module gpu_rail_seq
  import gpu_seq_pkg::*;
#(
  parameter int unsigned T_UP_SLOW  = 20,
  parameter int unsigned T_UP_FAST  = 5,
  parameter int unsigned T_DN_WAIT  = 20,
  parameter int unsigned T_HOLD     = 1,
  parameter int unsigned T_RST_LEAD = 5,
  parameter int unsigned T_DW_FB    = 40,
  parameter int unsigned T_DW_PEX   = 10,
  parameter int unsigned T_DW_CORE  = 2,
  parameter int unsigned T_DW_3V3   = 4,
  parameter logic [4:0]  EN_LOW_MASK = 5'b10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          pwr_on_req,
  input  logic          pwr_off_req,
  input  logic [NR-1:0] pg_in,
  output logic [NR-1:0] rail_en,
  output logic          rails_good,
  output logic          gpu_rst_n,
  output logic          busy,
  output logic          done,
  output logic          timeout_err
);
  localparam int unsigned TMAX = max2(max2(max2(T_UP_SLOW, T_UP_FAST), max2(T_DN_WAIT, T_HOLD)),
                                      max2(max2(T_RST_LEAD, T_DW_FB),
                                           max2(max2(T_DW_PEX, T_DW_CORE), T_DW_3V3)));
  localparam int unsigned TW = $clog2(TMAX + 2);
  localparam rail_idx_t   LAST = rail_idx_t'(NR - 1);

  seq_st_t        st, st_nxt;
  rail_idx_t      idx;
  logic [NR-1:0]  en_q, pg_s;
  logic [TW-1:0]  tmr, limit;
  logic           tmr_exp, pg_ok, step_end, restart;

  function automatic logic [TW-1:0] up_bound(input rail_idx_t r);
    return (r < 3'd2) ? TW'(T_UP_SLOW) : TW'(T_UP_FAST);
  endfunction

  function automatic logic [TW-1:0] dwell_for(input rail_idx_t r);
    case (r)
      3'd4:    return TW'(T_DW_FB);
      3'd3:    return TW'(T_DW_PEX);
      3'd2:    return TW'(T_DW_CORE);
      3'd1:    return TW'(T_DW_3V3);
      default: return '0;
    endcase
  endfunction

  pg_sync #(.W(NR)) u_sync (.clk(clk), .rst_n(rst_n), .raw(pg_in), .sync(pg_s));

  ms_timer #(.W(TW)) u_tmr (.clk(clk), .rst_n(rst_n), .restart(restart),
                            .tick(ms_tick), .count(tmr));

  always_comb begin
    limit = '0;
    pg_ok = 1'b0;
    case (st)
      S_UP_PG:    begin limit = up_bound(idx);   pg_ok = pg_s[idx];  end
      S_UP_HOLD:  limit = TW'(T_HOLD);
      S_DN_RST:   limit = TW'(T_RST_LEAD);
      S_DN_PG:    begin limit = TW'(T_DN_WAIT);  pg_ok = !pg_s[idx]; end
      S_DN_DWELL: limit = dwell_for(idx);
      default:    limit = '0;
    endcase
    tmr_exp  = (tmr >= limit);
    step_end = pg_ok || tmr_exp;

    st_nxt = st;
    case (st)
      S_IDLE:     if (pwr_on_req) st_nxt = S_UP_ON;
                  else if (pwr_off_req) st_nxt = S_DN_RST;
      S_UP_ON:    st_nxt = S_UP_PG;
      S_UP_PG:    if (step_end) st_nxt = (idx == LAST) ? S_UP_HOLD : S_UP_ON;
      S_UP_HOLD:  if (step_end) st_nxt = S_DONE;
      S_DN_RST:   if (step_end) st_nxt = S_DN_OFF;
      S_DN_OFF:   st_nxt = S_DN_PG;
      S_DN_PG:    if (step_end) st_nxt = (idx == 3'd0) ? S_DONE : S_DN_DWELL;
      S_DN_DWELL: if (step_end) st_nxt = S_DN_OFF;
      default:    st_nxt = S_IDLE;
    endcase
  end

  assign restart = (st_nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      idx         <= '0;
      en_q        <= '0;
      rails_good  <= 1'b0;
      gpu_rst_n   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      st <= st_nxt;
      case (st)
        S_IDLE: if (st_nxt != S_IDLE) begin
          timeout_err <= 1'b0;
          gpu_rst_n   <= 1'b0;
          if (st_nxt == S_UP_ON) begin
            rails_good <= 1'b0;
            idx        <= '0;
          end else begin
            idx <= LAST;
          end
        end
        S_UP_ON:  en_q[idx] <= 1'b1;
        S_UP_PG: if (step_end) begin
          if (!pg_ok) timeout_err <= 1'b1;
          if (idx != LAST) idx <= idx + 3'd1;
          else rails_good <= 1'b1;
        end
        S_UP_HOLD:  if (step_end) gpu_rst_n  <= 1'b1;
        S_DN_RST:   if (step_end) rails_good <= 1'b0;
        S_DN_OFF:   en_q[idx] <= 1'b0;
        S_DN_PG:    if (step_end && !pg_ok) timeout_err <= 1'b1;
        S_DN_DWELL: if (step_end) idx <= idx - 3'd1;
        default: ;
      endcase
    end
  end

  assign rail_en = to_pins(en_q, EN_LOW_MASK);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);

  for (genvar r = 1; r < NR; r++) begin : g_up_ord
    assert_up_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[r]) |-> en_q[r-1]);
  end
  for (genvar r = 0; r < NR - 1; r++) begin : g_dn_ord
    assert_dn_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[r]) |-> !en_q[r+1]);
  end

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpu_rst_n) |-> rails_good);
  assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rails_good) |-> !gpu_rst_n);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && (busy || !(pwr_on_req || pwr_off_req))) |=> timeout_err);
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: tb/gpu_rail_seq_test.sv
module gpu_rail_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;
  localparam int PG_DLY     = 5;
  localparam logic [4:0] EN_LOW = 5'b10000;
  localparam logic [4:0] ALL_ON = 5'b01111;
  localparam logic [4:0] ALL_OFF = 5'b10000;

  // {op(1=on), stuck[4:0], exp_err, exp_rail_en[4:0], exp_good, exp_rstn}
  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 5'b00000, 1'b0, ALL_ON,  1'b1, 1'b1},
    {1'b0, 5'b00000, 1'b0, ALL_OFF, 1'b0, 1'b0},
    {1'b1, 5'b00001, 1'b1, ALL_ON,  1'b1, 1'b1},
    {1'b0, 5'b00000, 1'b0, ALL_OFF, 1'b0, 1'b0},
    {1'b1, 5'b00100, 1'b1, ALL_ON,  1'b1, 1'b1},
    {1'b0, 5'b00000, 1'b0, ALL_OFF, 1'b0, 1'b0},
    {1'b1, 5'b00000, 1'b0, ALL_ON,  1'b1, 1'b1},
    {1'b0, 5'b10000, 1'b1, ALL_OFF, 1'b0, 1'b0},
    {1'b1, 5'b00000, 1'b0, ALL_ON,  1'b1, 1'b1},
    {1'b0, 5'b00000, 1'b0, ALL_OFF, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic pwr_on_req = 1'b0, pwr_off_req = 1'b0;
  logic [4:0] pg_raw = '0, stuck = '0;
  logic [4:0] rail_en;
  logic rails_good, gpu_rst_n, busy, done, timeout_err;

  int checks = 0, errors = 0;

  gpu_rail_seq uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req), .pg_in(pg_raw),
    .rail_en(rail_en), .rails_good(rails_good), .gpu_rst_n(gpu_rst_n),
    .busy(busy), .done(done), .timeout_err(timeout_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int up_bound(input int r);
    return (r < 2) ? 20 : 5;
  endfunction

  function automatic int dwell_of(input int r);
    case (r)
      4: return 40;
      3: return 10;
      2: return 2;
      1: return 4;
      default: return 0;
    endcase
  endfunction

  // environment: monitor first, then drive the tick and the rail model
  int dly[5], t_en[5], t_fall[5], c_rise[5];
  int t_rg = 0, t_rst = 0, div = 0;
  logic [4:0] en_prev = '0;
  logic rg_prev = 1'b0, rst_prev = 1'b0;

  initial begin
    for (int i = 0; i < 5; i++) begin
      dly[i] = 0; t_en[i] = 0; t_fall[i] = 0; c_rise[i] = 0;
    end
    forever begin
      logic [4:0] en_l;
      @(negedge clk);
      en_l = rail_en ^ EN_LOW;
      if (rst_n) begin
        for (int i = 0; i < 5; i++) begin
          if (en_l[i] && !en_prev[i]) begin
            if (i > 0) begin
              if (!stuck[i-1]) begin
                check(pg_raw[i-1], "R2 enable before previous power-good", 0, 1);
                check(c_rise[i-1] >= 4, "R11 clocks from power-good to next enable", c_rise[i-1], 4);
              end else begin
                check(t_en[i-1] >= up_bound(i-1) && t_en[i-1] <= up_bound(i-1) + 1,
                      "R4 power-up timeout ticks", t_en[i-1], up_bound(i-1));
              end
            end
            t_en[i] = 0;
          end
          if (!en_l[i] && en_prev[i] && i < 4) begin
            if (!stuck[i+1]) begin
              check(!pg_raw[i+1], "R7 disable before previous power-good fell", 1, 0);
              check(t_fall[i+1] >= dwell_of(i+1) && t_fall[i+1] <= dwell_of(i+1) + 1,
                    "R8 discharge dwell ticks", t_fall[i+1], dwell_of(i+1));
            end
          end
        end
        if (rails_good && !rg_prev) t_rg = 0;
        if (gpu_rst_n && !rst_prev) check(t_rg == 1, "R5 rails-good to reset release ticks", t_rg, 1);
        if (!gpu_rst_n && rst_prev) t_rst = 0;
        if (!rails_good && rg_prev) check(t_rst == 5, "R6 reset to rails-good drop ticks", t_rst, 5);
      end
      en_prev = en_l; rg_prev = rails_good; rst_prev = gpu_rst_n;
      for (int i = 0; i < 5; i++) begin
        if (stuck[i] || pg_raw[i] == en_l[i]) dly[i] = 0;
        else dly[i]++;
        if (dly[i] == PG_DLY) begin
          pg_raw[i] = en_l[i];
          dly[i] = 0;
          if (en_l[i]) c_rise[i] = 0;
          else t_fall[i] = 0;
        end
        c_rise[i]++;
      end
      ms_tick = (div == 0);
      div = (div + 1) % TICK_DIV;
      if (ms_tick) begin
        t_rg++; t_rst++;
        for (int i = 0; i < 5; i++) begin t_en[i]++; t_fall[i]++; end
      end
    end
  end

  task automatic pulse(input logic on, input logic off, input logic expect_accept);
    @(negedge clk);
    pwr_on_req = on; pwr_off_req = off;
    @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    if (expect_accept) begin
      check(busy, "R12 busy after accepted request", busy, 1);
      check(!timeout_err, "R9 flag cleared by new request", timeout_err, 0);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    int width = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    check(done, "R12 sequence finished", done, 1);
    while (done && width < 10) begin
      check(busy, "R12 busy during done", busy, 1);
      width++;
      @(negedge clk);
    end
    check(width == 1, "R12 done pulse width", width, 1);
    check(!busy, "R12 busy low after done", busy, 0);
  endtask

  task automatic check_reset_state(input string tag);
    check(rail_en == ALL_OFF, {tag, " rail_en"}, rail_en, ALL_OFF);
    check(!rails_good && !gpu_rst_n, {tag, " rails_good/gpu_rst_n"}, {rails_good, gpu_rst_n}, 0);
    check(!busy && !done && !timeout_err, {tag, " busy/done/err"}, {busy, done, timeout_err}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after reset");

    for (int k = 0; k < NV; k++) begin
      logic [13:0] v;
      v = VEC[k];
      stuck = v[12:8];
      pulse(v[13], !v[13], 1'b1);
      wait_done();
      check(rail_en == v[6:2], "R3 rail_en pin levels", rail_en, v[6:2]);
      check(rails_good == v[1], "R5/R6 rails_good level", rails_good, v[1]);
      check(gpu_rst_n == v[0], "R5/R6 gpu_rst_n level", gpu_rst_n, v[0]);
      check(timeout_err == v[7], "R4/R7 timeout flag", timeout_err, v[7]);
      repeat (30) @(negedge clk);
      check(timeout_err == v[7], "R9 flag holds while idle", timeout_err, v[7]);
      stuck = '0;
      repeat (20) @(negedge clk);
    end

    // R10: power-off request during power-up is ignored
    pulse(1'b1, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    pulse(1'b0, 1'b1, 1'b0);
    wait_done();
    check(rail_en == ALL_ON && rails_good && gpu_rst_n, "R10 power-up not aborted", rail_en, ALL_ON);
    repeat (20) @(negedge clk);
    check(!busy, "R10 ignored request not queued", busy, 0);

    // R10: power-on request during power-down is ignored
    pulse(1'b0, 1'b1, 1'b1);
    repeat (100) @(negedge clk);
    pulse(1'b1, 1'b0, 1'b0);
    wait_done();
    check(rail_en == ALL_OFF && !rails_good, "R10 power-down not aborted", rail_en, ALL_OFF);
    repeat (20) @(negedge clk);
    check(!busy, "R10 ignored request not queued", busy, 0);

    // R13: simultaneous requests while idle
    pulse(1'b1, 1'b1, 1'b1);
    wait_done();
    check(rail_en == ALL_ON && gpu_rst_n, "R13 power-on wins", rail_en, ALL_ON);
    pulse(1'b0, 1'b1, 1'b1);
    wait_done();
    repeat (20) @(negedge clk);

    // R1: reset in the middle of a power-up
    pulse(1'b1, 1'b0, 1'b1);
    repeat (25) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state("R1 mid-sequence reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after mid-sequence reset");
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule